// File: doc/BRIEF.md
# Color-Matched Tile Pack Texel Addresser

This block turns the description of one edge-colored texture tile into the texel coordinate to read from a packed tile atlas. The atlas holds every possible tile exactly once. It is laid out so that any two tiles sitting side by side in it agree on the color of the edge they share, and this holds across the wrap from the last column to the first and from the last row to the first. Filtering hardware downstream can therefore read across a tile border in the atlas without producing a seam.

Each request carries four edge colors (south, east, north, west) and a fixed-point fraction for the sample position inside the tile on each axis. The block reduces the west/east color pair to a column of the atlas and the south/north pair to a row. Each reduction follows an ordering of color pairs that forms a closed walk through every ordered pair. The block then scales the column and row by the tile size and adds the integer texel offset inside the tile. The result is registered, so it appears one cycle after the request. Only compares, adds and small multiplies are used.

The number of colors on each axis, the tile width and height in texels, and the fraction width are parameters. The atlas is `KV*KV` tiles wide, where `KV` is the east/west color count, and `KH*KH` tiles tall, where `KH` is the south/north color count.

Top module: `wang_pack_addr`

## Requirements
- R1: While `rst_n` is low, and after it, until the first accepted request, `out_valid` is 0 and both texel outputs are 0.
- R2: For a color pair (a, b) with a < b, the tile slot is 2·a + b·b.
- R3: For a color pair with a == b, the slot is 0 when a is 0 and (a+1)·(a+1) − 2 otherwise.
- R4: For a color pair with a > b, the slot is a·a + 2·b − 1 when b > 0 and (a+1)·(a+1) − 1 when b is 0.
- R5: The column slot uses the pair (west, east), and west/east colors are below `KV`. The row slot uses the pair (south, north), and south/north colors are below `KH`.
- R6: Over all pairs of one axis with K colors, the slots are a permutation of 0..K·K−1.
- R7: The tile in slot i has an east (or north) color equal to the west (or south) color of the tile in slot (i+1) mod K·K. This includes the wrap from the last slot to slot 0.
- R8: The in-tile offset is floor(frac · T / 2^FRAC_W), where T is the tile size on that axis. It covers fraction 0 (offset 0) and the all-ones fraction (offset T−1).
- R9: `texel_h` = column slot · `TILE_W` + horizontal offset, and `texel_v` = row slot · `TILE_H` + vertical offset.
- R10: A request with `in_valid` high is reflected on the outputs, with `out_valid` high, exactly one clock later.
- R11: A cycle with `in_valid` low drives `out_valid` low on the next cycle and leaves both texel outputs unchanged, whatever the other inputs carry.
- R12: `texel_h` stays below `KV*KV*TILE_W` and `texel_v` stays below `KH*KH*TILE_H`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request present this cycle |
| edge_s | input | clog2(KH) | South edge color |
| edge_e | input | clog2(KV) | East edge color |
| edge_n | input | clog2(KH) | North edge color |
| edge_w | input | clog2(KV) | West edge color |
| frac_h | input | FRAC_W | Horizontal in-tile fraction, unsigned fixed point |
| frac_v | input | FRAC_W | Vertical in-tile fraction, unsigned fixed point |
| out_valid | output | 1 | Texel address valid |
| texel_h | output | clog2(KV*KV*TILE_W) | Horizontal texel coordinate in the atlas |
| texel_v | output | clog2(KH*KH*TILE_H) | Vertical texel coordinate in the atlas |

## Verification
The bench uses a square-free configuration: four east/west colors against three south/north colors, and tiles 16 wide by 8 tall. A swap of the axes, or of the two colors in a pair, therefore lands in a different place. Every color combination is driven with a fraction that varies from request to request. This separates the below-diagonal, on-diagonal and above-diagonal branches of the slot formula, as well as the zero-color special cases. The bench collects the slots it observes on each axis and tests them for a full permutation and for matching neighbours, including the wrap. Fractions of zero and all ones probe both ends of the offset scaling. An idle cycle carrying different colors shows that the outputs hold.

// File: rtl/wtp_pkg.sv
package wtp_pkg;

    // Bit width able to hold values 0..n-1, never below one bit.
    function automatic int width_for(input int n);
        int w;
        w = 1;
        while ((1 << w) < n) begin
            w = w + 1;
        end
        return w;
    endfunction

endpackage

// File: rtl/wtp_pair_slot.sv
module wtp_pair_slot #(
    parameter int K = 4
) (
    input  logic [wtp_pkg::width_for(K)-1:0]   col_a,
    input  logic [wtp_pkg::width_for(K)-1:0]   col_b,
    output logic [wtp_pkg::width_for(K*K)-1:0] slot
);
    localparam int SLOT_W = wtp_pkg::width_for(K*K);

    int unsigned a_u;
    int unsigned b_u;
    int unsigned res;

    always_comb begin
        a_u = 32'(col_a);
        b_u = 32'(col_b);
        if (a_u < b_u) begin
            res = 2 * a_u + b_u * b_u;
        end else if (a_u == b_u) begin
            if (a_u == 0) begin
                res = 0;
            end else begin
                res = (a_u + 1) * (a_u + 1) - 2;
            end
        end else begin
            if (b_u == 0) begin
                res = (a_u + 1) * (a_u + 1) - 1;
            end else begin
                res = a_u * a_u + 2 * b_u - 1;
            end
        end
        slot = SLOT_W'(res);
    end

endmodule

// File: rtl/wtp_tile_offset.sv
module wtp_tile_offset #(
    parameter int TILE   = 16,
    parameter int FRAC_W = 8
) (
    input  logic [FRAC_W-1:0]                  frac,
    output logic [wtp_pkg::width_for(TILE)-1:0] offset
);
    localparam int OFF_W  = wtp_pkg::width_for(TILE);
    localparam int PROD_W = FRAC_W + OFF_W + 1;

    logic [PROD_W-1:0] prod;

    always_comb begin
        prod   = PROD_W'(frac) * PROD_W'(TILE);
        offset = prod[FRAC_W +: OFF_W];
    end

endmodule

// File: rtl/wang_pack_addr.sv
module wang_pack_addr #(
    parameter int KH     = 3,
    parameter int KV     = 4,
    parameter int TILE_W = 16,
    parameter int TILE_H = 8,
    parameter int FRAC_W = 8
) (
    input  logic                                         clk,
    input  logic                                         rst_n,
    input  logic                                         in_valid,
    input  logic [wtp_pkg::width_for(KH)-1:0]            edge_s,
    input  logic [wtp_pkg::width_for(KV)-1:0]            edge_e,
    input  logic [wtp_pkg::width_for(KH)-1:0]            edge_n,
    input  logic [wtp_pkg::width_for(KV)-1:0]            edge_w,
    input  logic [FRAC_W-1:0]                            frac_h,
    input  logic [FRAC_W-1:0]                            frac_v,
    output logic                                         out_valid,
    output logic [wtp_pkg::width_for(KV*KV*TILE_W)-1:0]  texel_h,
    output logic [wtp_pkg::width_for(KH*KH*TILE_H)-1:0]  texel_v
);
    localparam int COLS     = KV * KV;
    localparam int ROWS     = KH * KH;
    localparam int SLOT_H_W = wtp_pkg::width_for(COLS);
    localparam int SLOT_V_W = wtp_pkg::width_for(ROWS);
    localparam int OFF_H_W  = wtp_pkg::width_for(TILE_W);
    localparam int OFF_V_W  = wtp_pkg::width_for(TILE_H);
    localparam int ADDR_H_W = wtp_pkg::width_for(COLS * TILE_W);
    localparam int ADDR_V_W = wtp_pkg::width_for(ROWS * TILE_H);

    logic [SLOT_H_W-1:0] col_slot;
    logic [SLOT_V_W-1:0] row_slot;
    logic [OFF_H_W-1:0]  off_h;
    logic [OFF_V_W-1:0]  off_v;
    logic [ADDR_H_W-1:0] addr_h_nxt;
    logic [ADDR_V_W-1:0] addr_v_nxt;

    // Column from the west/east pair, row from the south/north pair.
    wtp_pair_slot #(.K(KV)) u_col_slot (
        .col_a (edge_w),
        .col_b (edge_e),
        .slot  (col_slot)
    );

    wtp_pair_slot #(.K(KH)) u_row_slot (
        .col_a (edge_s),
        .col_b (edge_n),
        .slot  (row_slot)
    );

    wtp_tile_offset #(.TILE(TILE_W), .FRAC_W(FRAC_W)) u_off_h (
        .frac   (frac_h),
        .offset (off_h)
    );

    wtp_tile_offset #(.TILE(TILE_H), .FRAC_W(FRAC_W)) u_off_v (
        .frac   (frac_v),
        .offset (off_v)
    );

    always_comb begin
        addr_h_nxt = ADDR_H_W'(col_slot) * ADDR_H_W'(TILE_W) + ADDR_H_W'(off_h);
        addr_v_nxt = ADDR_V_W'(row_slot) * ADDR_V_W'(TILE_H) + ADDR_V_W'(off_v);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            texel_h   <= '0;
            texel_v   <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                texel_h <= addr_h_nxt;
                texel_v <= addr_v_nxt;
            end
        end
    end

    AST_COLOR_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |-> (32'(edge_w) < KV && 32'(edge_e) < KV && 32'(edge_s) < KH && 32'(edge_n) < KH)); // R5
    AST_COL_SLOT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |-> 32'(col_slot) < COLS); // R6
    AST_ROW_SLOT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |-> 32'(row_slot) < ROWS); // R6
    AST_OFFSET_IN_TILE: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |-> (32'(off_h) < TILE_W && 32'(off_v) < TILE_H)); // R8
    AST_ADDR_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (32'(texel_h) < COLS * TILE_W && 32'(texel_v) < ROWS * TILE_H)); // R12
    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && $stable(texel_h) && $stable(texel_v))); // R11

endmodule

// File: tb/sim_wang_pack_addr.sv
`timescale 1ns/1ps
module sim_wang_pack_addr;
    localparam int KH = 3;
    localparam int KV = 4;
    localparam int TW = 16;
    localparam int TH = 8;
    localparam int FW = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_valid = 1'b0;
    logic [1:0] edge_s = '0;
    logic [1:0] edge_e = '0;
    logic [1:0] edge_n = '0;
    logic [1:0] edge_w = '0;
    logic [FW-1:0] frac_h = '0;
    logic [FW-1:0] frac_v = '0;
    logic       out_valid;
    logic [7:0] texel_h;
    logic [6:0] texel_v;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    int west_at [KV*KV];
    int east_at [KV*KV];
    int hits_h  [KV*KV];
    int south_at[KH*KH];
    int north_at[KH*KH];
    int hits_v  [KH*KH];

    always #10 clk = ~clk;

    wang_pack_addr #(.KH(KH), .KV(KV), .TILE_W(TW), .TILE_H(TH), .FRAC_W(FW)) u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
        .edge_s(edge_s), .edge_e(edge_e), .edge_n(edge_n), .edge_w(edge_w),
        .frac_h(frac_h), .frac_v(frac_v),
        .out_valid(out_valid), .texel_h(texel_h), .texel_v(texel_v)
    );

    function automatic int exp_slot(input int a, input int b);
        if (a < b) return 2 * a + b * b;
        if (a == b) return (a == 0) ? 0 : (a + 1) * (a + 1) - 2;
        if (b == 0) return (a + 1) * (a + 1) - 1;
        return a * a + 2 * b - 1;
    endfunction

    function automatic string tag_of(input int a, input int b);
        if (a < b) return "R2";
        if (a == b) return "R3";
        return "R4";
    endfunction

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic issue(input int w, input int e, input int s, input int n,
                         input int fh, input int fv);
        @(negedge clk);
        in_valid = 1'b1;
        edge_w = 2'(w); edge_e = 2'(e); edge_s = 2'(s); edge_n = 2'(n);
        frac_h = FW'(fh); frac_v = FW'(fv);
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    initial begin
        #(200000 * 20);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int prev_h;
        int prev_v;
        for (int i = 0; i < KV*KV; i++) hits_h[i] = 0;
        for (int i = 0; i < KH*KH; i++) hits_v[i] = 0;

        // R1: reset state
        repeat (3) @(negedge clk);
        chk("R1 valid", int'(out_valid), 0);
        chk("R1 texel_h", int'(texel_h), 0);
        chk("R1 texel_v", int'(texel_v), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 valid after release", int'(out_valid), 0);
        chk("R1 texel_h after release", int'(texel_h), 0);

        // Full sweep: R2 R3 R4 R5 R9 R10, offsets varied (R8)
        for (int w = 0; w < KV; w++) begin
            for (int e = 0; e < KV; e++) begin
                for (int s = 0; s < KH; s++) begin
                    for (int n = 0; n < KH; n++) begin
                        int fh;
                        int fv;
                        int eh;
                        int ev;
                        fh = (w * 61 + e * 37 + s * 13 + n * 5) % 256;
                        fv = (n * 59 + s * 31 + e * 11 + w * 3) % 256;
                        issue(w, e, s, n, fh, fv);
                        eh = exp_slot(w, e) * TW + (fh * TW) / 256;
                        ev = exp_slot(s, n) * TH + (fv * TH) / 256;
                        chk("R10 out_valid", int'(out_valid), 1);
                        chk({tag_of(w, e), " R5 R9 texel_h"}, int'(texel_h), eh);
                        chk({tag_of(s, n), " R5 R9 texel_v"}, int'(texel_v), ev);
                        chk("R12 texel_h bound", int'(int'(texel_h) < KV*KV*TW), 1);
                        if (s == 0 && n == 0) begin
                            int k;
                            k = int'(texel_h) / TW;
                            hits_h[k]++;
                            west_at[k] = w;
                            east_at[k] = e;
                        end
                        if (w == 0 && e == 0) begin
                            int k;
                            k = int'(texel_v) / TH;
                            hits_v[k]++;
                            south_at[k] = s;
                            north_at[k] = n;
                        end
                    end
                end
            end
        end

        // R6: permutation on each axis
        for (int i = 0; i < KV*KV; i++) chk("R6 column slot hit once", hits_h[i], 1);
        for (int i = 0; i < KH*KH; i++) chk("R6 row slot hit once", hits_v[i], 1);
        // R7: neighbours match, including wrap
        for (int i = 0; i < KV*KV; i++)
            chk("R7 column neighbour", east_at[i], west_at[(i + 1) % (KV*KV)]);
        for (int i = 0; i < KH*KH; i++)
            chk("R7 row neighbour", north_at[i], south_at[(i + 1) % (KH*KH)]);

        // R8: fraction extremes
        issue(2, 3, 1, 2, 0, 0);
        chk("R8 zero frac h", int'(texel_h), exp_slot(2, 3) * TW);
        chk("R8 zero frac v", int'(texel_v), exp_slot(1, 2) * TH);
        issue(3, 0, 2, 0, 255, 255);
        chk("R8 full frac h", int'(texel_h), exp_slot(3, 0) * TW + TW - 1);
        chk("R8 full frac v", int'(texel_v), exp_slot(2, 0) * TH + TH - 1);
        chk("R12 top corner h", int'(texel_h), KV*KV*TW - 1);
        chk("R12 top corner v", int'(texel_v), KH*KH*TH - 1);

        // R11: idle cycle with changed inputs holds outputs
        prev_h = int'(texel_h);
        prev_v = int'(texel_v);
        edge_w = 2'd1; edge_e = 2'd1; edge_s = 2'd1; edge_n = 2'd0;
        frac_h = 8'd100; frac_v = 8'd200;
        @(negedge clk);
        chk("R11 out_valid low", int'(out_valid), 0);
        chk("R11 texel_h held", int'(texel_h), prev_h);
        chk("R11 texel_v held", int'(texel_v), prev_v);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule